// File: doc/BRIEF.md
# Looping Test Vector Sequencer

This block replays a compressed stream of test vectors. It holds a small pattern store of words, and each word carries an operation, an operand and one vector. After a start pulse the sequencer begins at address 0 and reads the words in turn. It drives one vector per valid cycle. Repeat words and counted loops are expanded in hardware, so the stream of valid vectors is the same as the original uncompressed cycle stream.

Loops can nest, and a small stack of iteration counters tracks them. A repeat word inside a loop body is expanded again on every pass. The stream ends when an exit word is reached, and a done flag is then raised. If loops nest too deeply, or a loop jump has no open loop, the sequencer stops with an error flag. The testbench loads the pattern store through a write port while the sequencer is idle. Between words the valid strobe drops for one cycle while the next word is read. Inside a repeat the strobe stays high.

Top module: `vecLoopSequencer`

## Requirements
- R1: A word is 19 bits: opcode in bits 18:16, operand in bits 15:8 and vector in bits 7:0. The opcodes are plain 0, repeat 1, loop-open 2, loop-jump 3 and exit 4. A plain word, or any word with opcode 5 to 7, drives its vector for exactly one valid cycle, and execution then moves to the next address.
- R2: A repeat word with operand N drives its vector for N valid cycles back to back, with no invalid cycle between them. An operand of 0 counts as 1.
- R3: A loop-open word with operand N drives its vector once and opens a loop of N passes. An operand of 0 counts as 1. The body runs from the next address through the matching loop-jump word.
- R4: A loop-jump word drives its vector on every pass. While passes remain, it branches to the address given in its operand. After the last pass it closes the loop and execution moves to the next address.
- R5: Loops nest up to 8 deep. Each loop counts its own passes. A repeat word inside a body is expanded in full on every pass.
- R6: A loop-open word met while 8 loops are already open drives no vector. It sets errFlag, and valid then stays low.
- R7: A loop-jump word met with no open loop drives no vector. It sets errFlag, and valid then stays low.
- R8: An exit word drives its vector once and then sets done. Done holds and valid stays low until the next start. A start given while done or errFlag is high restarts the sequencer from address 0, with the loops and both flags cleared.
- R9: A start pulse while a pattern is running has no effect on the vector stream.
- R10: After reset, outValid, done and errFlag are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a pattern at address 0 when idle, done or halted |
| memWrEn | input | 1 | Pattern store write enable |
| memWrAddr | input | ADDR_W (6) | Pattern store write address |
| memWrData | input | 19 | Pattern word to write |
| outVec | output | VEC_W (8) | Vector for the current cycle |
| outValid | output | 1 | outVec is a pattern cycle |
| done | output | 1 | Exit word has been applied |
| errFlag | output | 1 | Loop nesting fault, sequencer halted |

## Verification
The first valid vector appears two cycles after the edge that samples start: one cycle to read the word and one to drive it. Every later word costs one read cycle, plus one valid cycle for each vector it drives. The bench does not predict these cycle positions. It records outVec on each valid cycle at the falling edge and compares the recorded stream, in order and in length, against an expansion of the loaded program computed from the requirements. The flags are checked after they rise, and again five cycles later, which confirms that they hold and that no extra valid cycle follows.

// File: rtl/seqPkg.sv
package seqPkg;
  localparam int OP_W = 3;

  localparam logic [OP_W-1:0] OP_NOP  = 3'd0;
  localparam logic [OP_W-1:0] OP_RPT  = 3'd1;
  localparam logic [OP_W-1:0] OP_LOOP = 3'd2;
  localparam logic [OP_W-1:0] OP_JUMP = 3'd3;
  localparam logic [OP_W-1:0] OP_EXIT = 3'd4;

  // strobes from control to datapath
  typedef struct packed {
    logic clrAll;
    logic fetch;
    logic pcInc;
    logic pcJump;
    logic rptInc;
    logic rptClr;
    logic push;
    logic decTop;
    logic pop;
  } seqStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic [OP_W-1:0] op;
    logic            rptLast;
    logic            stackEmpty;
    logic            stackFull;
    logic            topLast;
  } seqStatus_t;
endpackage

// File: rtl/seqDatapath.sv
module seqDatapath
  import seqPkg::*;
#(
  parameter int VEC_W  = 8,
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 8,
  parameter int DEPTH  = 8,
  localparam int WORD_W = OP_W + CNT_W + VEC_W,
  localparam int SP_W   = $clog2(DEPTH + 1),
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              memWrEn,
  input  logic [ADDR_W-1:0] memWrAddr,
  input  logic [WORD_W-1:0] memWrData,
  input  seqStrobe_t        strb,
  output seqStatus_t        stat,
  output logic [VEC_W-1:0]  vecOut,
  output logic [SP_W-1:0]   depth
);
  localparam int MEM_D = 2 ** ADDR_W;

  logic [WORD_W-1:0] patMem [MEM_D];
  logic [WORD_W-1:0] instReg;
  logic [ADDR_W-1:0] pc;
  logic [CNT_W-1:0]  rptCnt;
  logic [SP_W-1:0]   sp;
  logic [CNT_W-1:0]  loopCnt [DEPTH];

  logic [OP_W-1:0]   instOp;
  logic [CNT_W-1:0]  instArg;
  logic [CNT_W-1:0]  effArg;
  logic [IDX_W-1:0]  topIdx;
  logic [CNT_W-1:0]  topCnt;
  logic [CNT_W:0]    rptNext;

  // pattern store, written by the loader port
  always_ff @(posedge clk) begin
    if (memWrEn) patMem[memWrAddr] <= memWrData;
  end

  // instruction register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           instReg <= '0;
    else if (strb.fetch) instReg <= patMem[pc];
  end

  assign instOp  = instReg[WORD_W-1 -: OP_W];
  assign instArg = instReg[VEC_W +: CNT_W];
  assign vecOut  = instReg[VEC_W-1:0];
  assign effArg  = (instArg == '0) ? CNT_W'(1) : instArg;

  // program counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            pc <= '0;
    else if (strb.clrAll) pc <= '0;
    else if (strb.pcJump) pc <= instArg[ADDR_W-1:0];
    else if (strb.pcInc)  pc <= pc + ADDR_W'(1);
  end

  // repeat cycle counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          rptCnt <= '0;
    else if (strb.clrAll || strb.rptClr) rptCnt <= '0;
    else if (strb.rptInc)               rptCnt <= rptCnt + CNT_W'(1);
  end

  assign rptNext = {1'b0, rptCnt} + (CNT_W + 1)'(1);

  // loop stack pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            sp <= '0;
    else if (strb.clrAll) sp <= '0;
    else if (strb.push)   sp <= sp + SP_W'(1);
    else if (strb.pop)    sp <= sp - SP_W'(1);
  end

  // one counter register per nesting level
  for (genvar g = 0; g < DEPTH; g++) begin : gLevel
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        loopCnt[g] <= '0;
      else if (strb.push && sp == SP_W'(g))
        loopCnt[g] <= effArg;
      else if (strb.decTop && sp == SP_W'(g + 1))
        loopCnt[g] <= loopCnt[g] - CNT_W'(1);
    end
  end

  assign topIdx = (sp == '0) ? '0 : IDX_W'(sp - SP_W'(1));
  assign topCnt = loopCnt[topIdx];

  always_comb begin
    stat.op         = instOp;
    stat.rptLast    = rptNext >= {1'b0, effArg};
    stat.stackEmpty = (sp == '0);
    stat.stackFull  = (sp == SP_W'(DEPTH));
    stat.topLast    = (topCnt <= CNT_W'(1));
  end

  assign depth = sp;
endmodule

// File: rtl/seqControl.sv
module seqControl
  import seqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  seqStatus_t stat,
  output seqStrobe_t strb,
  output logic       outValid,
  output logic       done,
  output logic       errFlag
);
  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_EXEC,
    S_DONE,
    S_HALT
  } seqState_e;

  seqState_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strb      = '0;
    outValid  = 1'b0;
    stateNext = state;
    unique case (state)
      S_IDLE, S_DONE, S_HALT: begin
        if (start) begin
          strb.clrAll = 1'b1;
          stateNext   = S_FETCH;
        end
      end
      S_FETCH: begin
        strb.fetch = 1'b1;
        stateNext  = S_EXEC;
      end
      S_EXEC: begin
        unique case (stat.op)
          OP_RPT: begin
            outValid = 1'b1;
            if (stat.rptLast) begin
              strb.rptClr = 1'b1;
              strb.pcInc  = 1'b1;
              stateNext   = S_FETCH;
            end else begin
              strb.rptInc = 1'b1;
            end
          end
          OP_LOOP: begin
            if (stat.stackFull) begin
              stateNext = S_HALT;
            end else begin
              outValid   = 1'b1;
              strb.push  = 1'b1;
              strb.pcInc = 1'b1;
              stateNext  = S_FETCH;
            end
          end
          OP_JUMP: begin
            if (stat.stackEmpty) begin
              stateNext = S_HALT;
            end else begin
              outValid = 1'b1;
              if (stat.topLast) begin
                strb.pop   = 1'b1;
                strb.pcInc = 1'b1;
              end else begin
                strb.decTop = 1'b1;
                strb.pcJump = 1'b1;
              end
              stateNext = S_FETCH;
            end
          end
          OP_EXIT: begin
            outValid  = 1'b1;
            stateNext = S_DONE;
          end
          default: begin
            outValid   = 1'b1;
            strb.pcInc = 1'b1;
            stateNext  = S_FETCH;
          end
        endcase
      end
      default: stateNext = S_IDLE;
    endcase
  end

  assign done    = (state == S_DONE);
  assign errFlag = (state == S_HALT);
endmodule

// File: rtl/vecLoopSequencer.sv
module vecLoopSequencer
  import seqPkg::*;
#(
  parameter int VEC_W  = 8,
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 8,
  parameter int DEPTH  = 8,
  localparam int WORD_W = OP_W + CNT_W + VEC_W,
  localparam int SP_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              memWrEn,
  input  logic [ADDR_W-1:0] memWrAddr,
  input  logic [WORD_W-1:0] memWrData,
  output logic [VEC_W-1:0]  outVec,
  output logic              outValid,
  output logic              done,
  output logic              errFlag
);
  seqStrobe_t      strb;
  seqStatus_t      stat;
  logic [SP_W-1:0] depth;

  seqControl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .stat     (stat),
    .strb     (strb),
    .outValid (outValid),
    .done     (done),
    .errFlag  (errFlag)
  );

  seqDatapath #(
    .VEC_W  (VEC_W),
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .DEPTH  (DEPTH)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .memWrEn   (memWrEn),
    .memWrAddr (memWrAddr),
    .memWrData (memWrData),
    .strb      (strb),
    .stat      (stat),
    .vecOut    (outVec),
    .depth     (depth)
  );
endmodule

// File: rtl/seqChecker.sv
module seqChecker
  import seqPkg::*;
#(
  parameter int VEC_W = 8,
  parameter int DEPTH = 8,
  localparam int SP_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [VEC_W-1:0] outVec,
  input logic             outValid,
  input logic             done,
  input logic             errFlag,
  input seqStatus_t       stat,
  input logic [SP_W-1:0]  depth
);
  // R2: an unfinished repeat keeps driving the same vector next cycle
  a_r2_rpt_no_bubble: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && stat.op == OP_RPT && !stat.rptLast) |=> (outValid && $stable(outVec)));

  // R5: nesting depth never passes its bound
  a_r5_depth_bound: assert property (@(posedge clk) disable iff (!rstN)
    depth <= SP_W'(DEPTH));

  // R6 R7: a halted sequencer stays quiet until restarted
  a_r6_halt_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !start) |=> (errFlag && !outValid));

  // R8: done holds with no vector until the next start
  a_r8_done_hold: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> (done && !outValid));

  // R8: the flags never both show
  a_r8_flags_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(done && errFlag));
endmodule

bind vecLoopSequencer seqChecker #(.VEC_W(VEC_W), .DEPTH(DEPTH)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .outVec   (outVec),
  .outValid (outValid),
  .done     (done),
  .errFlag  (errFlag),
  .stat     (stat),
  .depth    (depth)
);

// File: tb/tb_vecLoopSequencer.sv
module tb_vecLoopSequencer;
  localparam int VEC_W  = 8;
  localparam int ADDR_W = 6;
  localparam int WORD_W = 19;
  localparam int OBS_N  = 4096;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic              memWrEn = 1'b0;
  logic [ADDR_W-1:0] memWrAddr = '0;
  logic [WORD_W-1:0] memWrData = '0;
  logic [VEC_W-1:0]  outVec;
  logic              outValid;
  logic              done;
  logic              errFlag;

  always #5 clk = ~clk;

  vecLoopSequencer dut (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .memWrEn   (memWrEn),
    .memWrAddr (memWrAddr),
    .memWrData (memWrData),
    .outVec    (outVec),
    .outValid  (outValid),
    .done      (done),
    .errFlag   (errFlag)
  );

  int compared = 0;
  int mismatched = 0;

  logic [WORD_W-1:0] prog [64];
  logic [VEC_W-1:0]  obs [OBS_N];
  logic [VEC_W-1:0]  expv [OBS_N];
  int  obsCnt = 0;
  int  expCnt = 0;
  bit  expErr = 1'b0;
  bit  collect = 1'b0;

  always @(negedge clk) begin
    if (collect && outValid) begin
      if (obsCnt < OBS_N) obs[obsCnt] = outVec;
      obsCnt++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [WORD_W-1:0] mk(input int op, input int arg, input int vec);
    return {3'(op), 8'(arg), 8'(vec)};
  endfunction

  task automatic clearProg();
    for (int i = 0; i < 64; i++) prog[i] = mk(4, 0, 255);
  endtask

  task automatic loadProg();
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      memWrEn   = 1'b1;
      memWrAddr = ADDR_W'(i);
      memWrData = prog[i];
    end
    @(negedge clk);
    memWrEn = 1'b0;
  endtask

  // expansion of prog[] following the requirements
  task automatic expand();
    int pc = 0;
    int sp = 0;
    int stk [8];
    bit fin = 1'b0;
    expCnt = 0;
    expErr = 1'b0;
    for (int step = 0; step < 100000 && !fin; step++) begin
      int op  = int'(prog[pc][18:16]);
      int arg = int'(prog[pc][15:8]);
      int eff = (arg == 0) ? 1 : arg;
      logic [7:0] v = prog[pc][7:0];
      case (op)
        1: begin
          for (int k = 0; k < eff; k++) expv[expCnt++] = v;
          pc++;
        end
        2: begin
          if (sp == 8) begin expErr = 1'b1; fin = 1'b1; end
          else begin expv[expCnt++] = v; stk[sp] = eff; sp++; pc++; end
        end
        3: begin
          if (sp == 0) begin expErr = 1'b1; fin = 1'b1; end
          else begin
            expv[expCnt++] = v;
            if (stk[sp-1] > 1) begin stk[sp-1]--; pc = arg % 64; end
            else begin sp--; pc++; end
          end
        end
        4: begin expv[expCnt++] = v; fin = 1'b1; end
        default: begin expv[expCnt++] = v; pc++; end
      endcase
    end
  endtask

  task automatic runProg(input string req, input bit midStart);
    int cyc = 0;
    expand();
    loadProg();
    obsCnt  = 0;
    collect = 1'b1;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && !errFlag && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (midStart && cyc == 4) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
    if (cyc >= 20000) check(1'b0, {req, " watchdog"}, cyc, 0);
    check(errFlag == expErr, {req, " errFlag"}, int'(errFlag), int'(expErr));
    check(done == !expErr, {req, " done"}, int'(done), int'(!expErr));
    repeat (5) @(negedge clk);
    check(errFlag == expErr && done == !expErr, {req, " flags held"},
          int'({done, errFlag}), int'({!expErr, expErr}));
    collect = 1'b0;
    check(obsCnt == expCnt, {req, " vector count"}, obsCnt, expCnt);
    for (int i = 0; i < expCnt && i < obsCnt; i++)
      check(obs[i] == expv[i], {req, " vector"}, int'(obs[i]), int'(expv[i]));
  endtask

  initial begin
    clearProg();
    repeat (3) @(negedge clk);
    // R10: reset state
    check(!outValid && !done && !errFlag, "R10 reset", int'({outValid, done, errFlag}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!outValid && !done && !errFlag, "R10 after reset", int'({outValid, done, errFlag}), 0);

    // R1 R8: plain words, unused opcodes, exit
    clearProg();
    prog[0] = mk(0, 9, 8'h11);
    prog[1] = mk(5, 3, 8'h22);
    prog[2] = mk(7, 0, 8'h33);
    prog[3] = mk(0, 0, 8'h34);
    prog[4] = mk(4, 0, 8'h44);
    runProg("R1", 1'b0);

    // R2: repeat sweep, zero counts as one
    for (int n = 0; n <= 6; n++) begin
      clearProg();
      prog[0] = mk(0, 0, 8'h0A);
      prog[1] = mk(1, n, 8'h0B);
      prog[2] = mk(0, 0, 8'h0C);
      prog[3] = mk(4, 0, 8'h0D);
      runProg("R2", 1'b0);
    end

    // R3 R4: single loop sweep; R9 start pulse during a run
    for (int n = 0; n <= 5; n++) begin
      clearProg();
      prog[0] = mk(2, n, 8'h50);
      prog[1] = mk(0, 0, 8'h51);
      prog[2] = mk(0, 0, 8'h52);
      prog[3] = mk(3, 1, 8'h53);
      prog[4] = mk(4, 0, 8'h5F);
      runProg((n == 3) ? "R9" : "R3 R4", n == 3);
    end

    // R5: nested loops with a repeat in the inner body
    for (int a = 1; a <= 3; a++)
      for (int b = 0; b <= 3; b++)
        for (int r = 0; r <= 3; r++) begin
          clearProg();
          prog[0] = mk(2, a, 8'h60);
          prog[1] = mk(2, b, 8'h61);
          prog[2] = mk(1, r, 8'h62);
          prog[3] = mk(3, 2, 8'h63);
          prog[4] = mk(0, 0, 8'h64);
          prog[5] = mk(3, 1, 8'h65);
          prog[6] = mk(4, 0, 8'h66);
          runProg("R5", 1'b0);
        end

    // R5: full depth of 8
    clearProg();
    for (int i = 0; i < 8; i++) begin
      prog[i]      = mk(2, 2, 8'h70 + i);
      prog[15 - i] = mk(3, i + 1, 8'h80 + i);
    end
    prog[16] = mk(4, 0, 8'h8F);
    runProg("R5 depth8", 1'b0);

    // R6: ninth nested loop-open
    clearProg();
    for (int i = 0; i < 9; i++) prog[i] = mk(2, 1, 8'h90 + i);
    runProg("R6", 1'b0);

    // R7: loop-jump with nothing open
    clearProg();
    prog[0] = mk(0, 0, 8'hA0);
    prog[1] = mk(3, 0, 8'hA1);
    prog[2] = mk(4, 0, 8'hA2);
    runProg("R7", 1'b0);

    // R8: restart from a halted state
    clearProg();
    prog[0] = mk(1, 2, 8'hB0);
    prog[1] = mk(4, 0, 8'hB1);
    runProg("R8 restart", 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule